// File: doc/BRIEF.md
# Per-Channel Edge/Level Interrupt Unit

This unit watches a bank of already-synchronized input levels. It keeps one pending flag per channel and raises a single interrupt request line. Software chooses, channel by channel, between two detection modes. In edge mode any transition of the input is latched. In level mode the flag stays set for as long as the sampled input equals a programmed polarity. Only channels that are enabled and that the neighbouring GPIO bank has configured as inputs can set a flag.

Inputs are sampled once every `SAMPLE_DIV` clocks, so the delay from an input change to a pending flag is quantized to that sample period. Pending flags are cleared by writing 1s to the status bytes. A level condition that is still present sets its flag again at once. During an interrupt acknowledge cycle the unit presents an 8-bit vector byte. The host bus decode and the input synchronizers sit outside this block.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every enable, mode, polarity, status and vector bit reads 0 and `irq` is low.
- R2: Each 24-bit register is split into three bytes, with channel n at bit n%8 of byte offset base+n/8. The bases are: enable 0x0A, mode 0x0E, status 0x12, polarity 0x16. The vector is a single byte at 0x1A. Enable, mode, polarity and vector read back the last value written. Any other offset reads 0.
- R3: A mode bit of 1 selects edge mode. In edge mode a rising or a falling sample of an enabled input channel sets its status bit, whatever its polarity bit holds.
- R4: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A status bit falls only after such a write.
- R5: A channel whose enable bit is 0, or whose `dir_out` bit is 1, never sets its status bit.
- R6: `irq` is high while any enabled channel has a pending status bit. Once high, it falls only after a register write.
- R7: A mode bit of 0 selects level mode. In level mode the status bit sets while the sampled input equals the polarity bit (1 = high, 0 = low), and it sets again after a clear as long as that level persists.
- R8: While `iack` is high, `iack_data` carries the vector byte. Otherwise `iack_data` is 0.
- R9: In level mode, a change of `in_level` shows in the status bit no more than SAMPLE_DIV+1 clocks later.
- R10: A clear-write that lands in the same clock as a detection event on that channel leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_level | input | 24 | Synchronized channel input levels |
| dir_out | input | 24 | 1 = channel driven as output by the GPIO bank |
| bus_addr | input | 7 | Byte offset for register access |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr` |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_data | output | 8 | Vector byte during acknowledge |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checker watches four things on every cycle. No status bit may rise on a channel that was masked or driven as an output one cycle earlier. No status bit may fall unless a status byte was written. `irq` may not drop without a register write. A vector write must land in the vector register. What only the scenarios can show is the mode behaviour. That covers edge detection with polarity ignored, level matching against polarity, and re-assertion after a clear while the level is held. The scenarios also measure the latency bound set by the sample divider, check the byte layout and readback, and confirm that a clear and an event in the same cycle leave the bit set.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NBYTES = 3;
    localparam int NCH    = 8 * NBYTES;

    localparam logic [6:0] ADDR_EN  = 7'h0A;
    localparam logic [6:0] ADDR_TYP = 7'h0E;
    localparam logic [6:0] ADDR_ST  = 7'h12;
    localparam logic [6:0] ADDR_POL = 7'h16;
    localparam logic [6:0] ADDR_VEC = 7'h1A;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
    parameter int NCH        = 24,
    parameter int SAMPLE_DIV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] in_level,
    output logic [NCH-1:0] samp,
    output logic [NCH-1:0] edge_ev,
    output logic           primed
);
    localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [NCH-1:0] samp;
        logic           primed;
    } smp_t;

    smp_t s_d, s_q;
    logic tick;

    assign tick = (s_q.cnt == CW'(SAMPLE_DIV - 1));

    always_comb begin
        s_d = s_q;
        s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        if (tick) begin
            s_d.samp   = in_level;
            s_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // edge seen at the sample instant, against the previous sample
    assign edge_ev = (tick && s_q.primed) ? (in_level ^ s_q.samp) : '0;
    assign samp    = s_q.samp;
    assign primed  = s_q.primed;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [6:0]     bus_addr,
    input  logic           bus_wr,
    input  logic [7:0]     bus_wdata,
    output logic [NCH-1:0] en,
    output logic [NCH-1:0] typ,
    output logic [NCH-1:0] pol,
    output logic [7:0]     vec
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] typ;
        logic [NCH-1:0] pol;
        logic [7:0]     vec;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (bus_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (bus_addr == 7'(int'(ADDR_EN) + b))  c_d.en[b*8 +: 8]  = bus_wdata;
                if (bus_addr == 7'(int'(ADDR_TYP) + b)) c_d.typ[b*8 +: 8] = bus_wdata;
                if (bus_addr == 7'(int'(ADDR_POL) + b)) c_d.pol[b*8 +: 8] = bus_wdata;
            end
            if (bus_addr == ADDR_VEC) c_d.vec = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en  = c_q.en;
    assign typ = c_q.typ;
    assign pol = c_q.pol;
    assign vec = c_q.vec;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] typ,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] dir_out,
    input  logic [NCH-1:0] samp,
    input  logic [NCH-1:0] edge_ev,
    input  logic           primed,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] status
);
    logic [NCH-1:0] hit;
    logic [NCH-1:0] st_d, st_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic lvl_match;
        assign lvl_match = primed && (samp[i] == pol[i]);
        assign hit[i]    = en[i] && !dir_out[i] && (typ[i] ? edge_ev[i] : lvl_match);
    end

    always_comb begin
        // a fresh hit wins over a clear in the same cycle
        st_d = (st_q & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int SAMPLE_DIV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] in_level,
    input  logic [NCH-1:0] dir_out,
    input  logic [6:0]     bus_addr,
    input  logic           bus_wr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic           iack,
    output logic [7:0]     iack_data,
    output logic           irq
);
    logic [NCH-1:0] samp_w, edge_w, en_w, typ_w, pol_w, status_w, clr_w;
    logic [7:0]     vec_w;
    logic           primed_w;

    irq_sampler #(.NCH(NCH), .SAMPLE_DIV(SAMPLE_DIV)) u_smp (
        .clk(clk), .rst_n(rst_n), .in_level(in_level),
        .samp(samp_w), .edge_ev(edge_w), .primed(primed_w)
    );

    irq_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .en(en_w), .typ(typ_w), .pol(pol_w), .vec(vec_w)
    );

    always_comb begin
        clr_w = '0;
        if (bus_wr) begin
            for (int b = 0; b < NBYTES; b++)
                if (bus_addr == 7'(int'(ADDR_ST) + b)) clr_w[b*8 +: 8] = bus_wdata;
        end
    end

    irq_pending #(.NCH(NCH)) u_pend (
        .clk(clk), .rst_n(rst_n), .en(en_w), .typ(typ_w), .pol(pol_w),
        .dir_out(dir_out), .samp(samp_w), .edge_ev(edge_w), .primed(primed_w),
        .clr(clr_w), .status(status_w)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_addr == 7'(int'(ADDR_EN) + b))  bus_rdata = en_w[b*8 +: 8];
            if (bus_addr == 7'(int'(ADDR_TYP) + b)) bus_rdata = typ_w[b*8 +: 8];
            if (bus_addr == 7'(int'(ADDR_ST) + b))  bus_rdata = status_w[b*8 +: 8];
            if (bus_addr == 7'(int'(ADDR_POL) + b)) bus_rdata = pol_w[b*8 +: 8];
        end
        if (bus_addr == ADDR_VEC) bus_rdata = vec_w;
    end

    assign irq       = |(status_w & en_w);
    assign iack_data = iack ? vec_w : 8'h00;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [6:0]     bus_addr,
    input logic           bus_wr,
    input logic [7:0]     bus_wdata,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] dir_out,
    input logic [7:0]     vec,
    input logic           irq
);
    localparam logic [6:0] ST_LAST = 7'(int'(ADDR_ST) + NBYTES - 1);

    AST_NO_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(en & ~dir_out)) == '0)); // R5

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status) & ~status) != '0) |->
         $past(bus_wr && (bus_addr >= ADDR_ST) && (bus_addr <= ST_LAST)))); // R4

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq); // R6

    AST_VEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_VEC) |=> (vec == $past(bus_wdata))); // R8
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .status(status_w), .en(en_w), .dir_out(dir_out),
    .vec(vec_w), .irq(irq)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] in_level = '0;
    logic [23:0] dir_out = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        iack = 1'b0;
    logic [7:0]  iack_data;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl #(.SAMPLE_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .in_level(in_level), .dir_out(dir_out),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .iack(iack), .iack_data(iack_data), .irq(irq)
    );

    typedef struct packed {
        logic [4:0] ch;
        logic typ, pol, en, dout, l0, l1;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{5'd12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{5'd20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{5'd16, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{5'd22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd23, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr24(input logic [6:0] base, input logic [23:0] v);
        for (int b = 0; b < 3; b++) wr(7'(int'(base) + b), v[b*8 +: 8]);
    endtask

    task automatic rd24(input logic [6:0] base, output logic [23:0] v);
        logic [7:0] t;
        for (int b = 0; b < 3; b++) begin
            rd(7'(int'(base) + b), t);
            v[b*8 +: 8] = t;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic expect_set(input vec_t v);
        if (!v.en || v.dout) return 1'b0;
        if (v.typ) return v.l0 != v.l1;
        return (v.l0 == v.pol) || (v.l1 == v.pol);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [23:0] v24;
        logic [7:0]  b8;

        wait_cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd24(7'h0A, v24); check("R1 enable", 32'(v24), 0);
        rd24(7'h0E, v24); check("R1 mode", 32'(v24), 0);
        rd24(7'h12, v24); check("R1 status", 32'(v24), 0);
        rd24(7'h16, v24); check("R1 polarity", 32'(v24), 0);
        rd(7'h1A, b8);    check("R1 vector", 32'(b8), 0);
        check("R1 irq", 32'(irq), 0);

        // R2 layout and readback
        wr24(7'h0A, 24'hF03CA5);
        rd(7'h0B, b8); check("R2 enable byte1", 32'(b8), 32'h3C);
        rd24(7'h0A, v24); check("R2 enable", 32'(v24), 32'hF03CA5);
        wr24(7'h0E, 24'h5A9601); rd24(7'h0E, v24); check("R2 mode", 32'(v24), 32'h5A9601);
        wr24(7'h16, 24'h123456); rd24(7'h16, v24); check("R2 polarity", 32'(v24), 32'h123456);
        wr(7'h1A, 8'h5A); rd(7'h1A, b8); check("R2 vector", 32'(b8), 32'h5A);
        wr(7'h05, 8'hFF); rd(7'h05, b8); check("R2 unmapped", 32'(b8), 0);
        wr24(7'h0A, 24'h0); wr24(7'h0E, 24'h0); wr24(7'h16, 24'h0);
        wr24(7'h12, 24'hFFFFFF);

        // table: R3, R5, R7
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            logic e;
            v = TBL[i];
            e = expect_set(v);
            wr24(7'h0A, 24'h0);
            dir_out = '0; dir_out[v.ch] = v.dout;
            in_level = '0; in_level[v.ch] = v.l0;
            wr24(7'h0E, 24'(v.typ) << v.ch);
            wr24(7'h16, 24'(v.pol) << v.ch);
            wait_cyc(3 * DIV);
            wr24(7'h12, 24'hFFFFFF);
            wr24(7'h0A, 24'(v.en) << v.ch);
            wait_cyc(3 * DIV);
            @(negedge clk) in_level[v.ch] = v.l1;
            wait_cyc(3 * DIV);
            rd24(7'h12, v24);
            check(v.dout || !v.en ? "R5 table status" : (v.typ ? "R3 table status" : "R7 table status"),
                  32'(v24), 32'(24'(e) << v.ch));
            check("R6 table irq", 32'(irq), 32'(e));
        end
        wr24(7'h0A, 24'h0); dir_out = '0; in_level = '0;
        wr24(7'h12, 24'hFFFFFF);

        // R4 / R6 edge mode on channel 2
        wr24(7'h0E, 24'h000004); wr24(7'h16, 24'h0); wr24(7'h0A, 24'h000004);
        wait_cyc(3 * DIV);
        @(negedge clk) in_level[2] = 1'b1;
        wait_cyc(3 * DIV);
        check("R6 irq on pending", 32'(irq), 1);
        wr(7'h12, 8'h00);
        rd(7'h12, b8); check("R4 write 0 keeps", 32'(b8), 32'h04);
        check("R6 irq held", 32'(irq), 1);
        wr(7'h12, 8'hFB);
        rd(7'h12, b8); check("R4 other bits only", 32'(b8), 32'h04);
        wr(7'h12, 8'h04);
        rd(7'h12, b8); check("R4 write 1 clears", 32'(b8), 0);
        check("R6 irq released", 32'(irq), 0);

        // R7 / R10 level mode on channel 10
        wr24(7'h0A, 24'h0); wr24(7'h0E, 24'h0); wr24(7'h16, 24'h000400);
        in_level = '0;
        wait_cyc(3 * DIV);
        wr24(7'h12, 24'hFFFFFF);
        wr24(7'h0A, 24'h000400);
        wait_cyc(3 * DIV);
        rd(7'h13, b8); check("R7 no match no set", 32'(b8), 0);
        // R9 latency bound
        @(negedge clk) in_level[10] = 1'b1;
        wait_cyc(DIV + 1);
        #1 check("R9 latency", 32'(bus_rdata), 32'h04);
        wr(7'h13, 8'h04);
        rd(7'h13, b8); check("R10 clear with event", 32'(b8), 32'h04);
        wait_cyc(5);
        rd(7'h13, b8); check("R7 reassert held level", 32'(b8), 32'h04);
        check("R6 irq level", 32'(irq), 1);
        @(negedge clk) in_level[10] = 1'b0;
        wait_cyc(3 * DIV);
        wr(7'h13, 8'h04);
        wait_cyc(3 * DIV);
        rd(7'h13, b8); check("R7 cleared after removal", 32'(b8), 0);

        // R8 acknowledge
        @(negedge clk) iack = 1'b1;
        #1 check("R8 vector on ack", 32'(iack_data), 32'h5A);
        @(negedge clk) iack = 1'b0;
        #1 check("R8 idle zero", 32'(iack_data), 0);

        // R1 reset mid-run
        in_level[10] = 1'b1;
        wait_cyc(3 * DIV);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        rd24(7'h0A, v24); check("R1 enable after reset", 32'(v24), 0);
        rd24(7'h12, v24); check("R1 status after reset", 32'(v24), 0);
        rd(7'h1A, b8);    check("R1 vector after reset", 32'(b8), 0);
        check("R1 irq after reset", 32'(irq), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule